// File: doc/BRIEF.md
# Mode-Selectable Pixel-to-Link Word Packer

This block sits between an image sensor's parallel pixel bus and a serial link transmitter. Each pixel clock it may accept one input word with its line and frame sync flags. From these it builds an internal link word and sends it out with a one-cycle valid strobe. Line coding and serialization are done downstream.

The link word's width and contents follow five mode pins, and these pins may change at run time:
- A bus-width select picks a 32-bit word, carried in a 40-bit packet. Otherwise the word is 24 or 27 bits, carried in a 30-bit packet.
- A high-bandwidth select chooses between 27 and 24 bits. It only has an effect in the narrow setting.
- A pairing select packs two half-width input words into one link word. This lets the pixel clock run at twice the word rate.
- A check-field enable reserves the top six bits of the word for a CRC over the rest of the word.
- A sync-separation enable moves the sync flags out of the data slots and onto side outputs.

The block also reports the packet size that the current setting implies.

Top module: `link_word_packer`

## Requirements
- R1: While reset is low, and in the first cycle after it, `word_valid`, `word_data`, `word_hs` and `word_vs` are all zero.
- R2: `pkt_bits` is 40 when `mode_wide` is 1 and 30 when it is 0, as a combinational function of `mode_wide`.
- R3: When `mode_dbl` is 0, every accepted pixel (`pix_valid` high at a clock edge) produces exactly one word, with `word_valid` high in the cycle after that edge. No word appears without an accepted pixel.
- R4: When `sync_sep` is 0 and `mode_dbl` is 0, the word holds `pix_data` in bits 15:0, HSYNC in bit 16 and VSYNC in bit 17. `word_hs` and `word_vs` are then 0.
- R5: When `sync_sep` is 1, no sync flag enters the word. `word_hs` and `word_vs` carry the flags of the (first) pixel and are high only together with `word_valid`.
- R6: When `mode_dbl` is 1, accepted pixels are paired, and a word appears only after the second pixel of a pair. Each element holds the low 8 bits of `pix_data`. Without sync separation, each element is followed by its HSYNC bit and then its VSYNC bit, giving 10 bits; with sync separation the element is 8 bits. The first element sits in the low bits and the second directly above it.
- R7: The word is W bits wide: 32 when `mode_wide` is 1, 27 when `mode_wide` is 0 and `mode_hibw` is 1, and 24 otherwise. The payload capacity is W, or W-6 when `crc_en` is 1. Payload bits at or above the capacity are dropped, and every bit at or above W is 0.
- R8: With `crc_en` set, bits W-1:W-6 hold a CRC with polynomial x^6+x+1 and seed zero. It is taken MSB-first over bits 25:0 of the masked payload. Leading zero bits do not change it, so it equals the CRC over bits W-7:0.
- R9: `mode_hibw` has no effect on the word when `mode_wide` is 1.
- R10: Clearing `mode_dbl` while half a pair is held discards that half. The next pair starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wide | input | 1 | 1: 32-bit word, 40-bit packet; 0: narrow word, 30-bit packet |
| mode_hibw | input | 1 | Narrow width select: 1 gives 27 bits, 0 gives 24 bits |
| mode_dbl | input | 1 | Pair two half-width inputs per word |
| crc_en | input | 1 | Reserve top six bits for the CRC |
| sync_sep | input | 1 | Carry sync flags on side outputs instead of in the word |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_data | input | 16 | Pixel data |
| pix_hs | input | 1 | Line sync flag |
| pix_vs | input | 1 | Frame sync flag |
| word_valid | output | 1 | Link word strobe |
| word_data | output | 32 | Link word, zero above its width |
| word_hs | output | 1 | Separated line sync |
| word_vs | output | 1 | Separated frame sync |
| pkt_bits | output | 6 | Encoded packet size in bits |

## Verification
The bound properties assume the mode pins do not change in the cycle in which a word is formed. They also assume the mode pins stay the same while half a pair is held, except for the deliberate clearing of the pairing select covered by R10. The stimulus respects this by changing modes only when no pixel is presented, at least one idle cycle after the last word. Sync flags and data are driven freely, including patterns that overflow the capacity in paired mode with the check field. This exercises the truncation rule.

// File: rtl/lwp_pkg.sv
// Shared constants and types for the link word packer.
// Assumes the widest link word is 32 bits and the check field is 6 bits.
package lwp_pkg;
    localparam int WORD_MAX  = 32;
    localparam int WIDE_W    = 32;
    localparam int HIBW_W    = 27;
    localparam int BASE_W    = 24;
    localparam int CHK_W     = 6;
    localparam int PKT_WIDE  = 40;
    localparam int PKT_NARW  = 30;
    localparam logic [CHK_W-1:0] CHK_POLY = 6'h03;

    typedef logic [WORD_MAX-1:0] word_t;
    typedef logic [5:0]          wcount_t;
endpackage

// File: rtl/lwp_mode_decode.sv
// Turns the mode pins into word width, payload capacity and packet size.
// Assumes the pins are static inputs sampled by the caller; purely combinational.
module lwp_mode_decode
    import lwp_pkg::*;
(
    input  logic    mode_wide,
    input  logic    mode_hibw,
    input  logic    crc_en,
    output wcount_t word_w,
    output wcount_t cap_w,
    output wcount_t pkt_bits
);
    // Width, capacity and packet size selection.
    always_comb begin
        if (mode_wide)      word_w = wcount_t'(WIDE_W);
        else if (mode_hibw) word_w = wcount_t'(HIBW_W);
        else                word_w = wcount_t'(BASE_W);
        cap_w    = crc_en ? (word_w - wcount_t'(CHK_W)) : word_w;
        pkt_bits = mode_wide ? wcount_t'(PKT_WIDE) : wcount_t'(PKT_NARW);
    end
endmodule

// File: rtl/lwp_pair_gather.sv
// Collects one pixel (single mode) or a pair of half-width pixels (paired
// mode) and presents the raw payload, with sync flags inline or separated.
// Assumes PIX_W is even; the first pixel of a pair lands in the low bits.
module lwp_pair_gather #(
    parameter int PIX_W = 16,
    localparam int HALF_W = PIX_W / 2,
    localparam int PAY_W  = PIX_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_dbl,
    input  logic             sync_sep,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_hs,
    input  logic             pix_vs,
    output logic             fire,
    output logic [PAY_W-1:0] payload,
    output logic             side_hs,
    output logic             side_vs
);
    logic              pend_q;
    logic [HALF_W-1:0] hold_d_q;
    logic              hold_hs_q;
    logic              hold_vs_q;

    // Track whether the first half of a pair is held, and capture it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            hold_d_q  <= '0;
            hold_hs_q <= 1'b0;
            hold_vs_q <= 1'b0;
        end else if (!mode_dbl) begin
            pend_q <= 1'b0;
        end else if (pix_valid) begin
            pend_q <= !pend_q;
            if (!pend_q) begin
                hold_d_q  <= pix_data[HALF_W-1:0];
                hold_hs_q <= pix_hs;
                hold_vs_q <= pix_vs;
            end
        end
    end

    // A word is ready on every single-mode pixel or on the second of a pair.
    assign fire = pix_valid && (!mode_dbl || pend_q);

    // Arrange the payload bits for the current mode.
    always_comb begin
        payload = '0;
        if (!mode_dbl) begin
            if (sync_sep) payload = PAY_W'(pix_data);
            else          payload = PAY_W'({pix_vs, pix_hs, pix_data});
        end else begin
            if (sync_sep) payload = PAY_W'({pix_data[HALF_W-1:0], hold_d_q});
            else          payload = PAY_W'({pix_vs, pix_hs, pix_data[HALF_W-1:0],
                                            hold_vs_q, hold_hs_q, hold_d_q});
        end
    end

    // Separated sync flags follow the first pixel of the word.
    always_comb begin
        side_hs = 1'b0;
        side_vs = 1'b0;
        if (sync_sep) begin
            side_hs = mode_dbl ? hold_hs_q : pix_hs;
            side_vs = mode_dbl ? hold_vs_q : pix_vs;
        end
    end
endmodule

// File: rtl/lwp_word_format.sv
// Masks the payload to the capacity of the selected word and, when enabled,
// places a 6-bit CRC (x^6+x+1, zero seed, MSB first) in the top six bits.
// Assumes word_w is one of 24, 27 or 32; purely combinational.
module lwp_word_format
    import lwp_pkg::*;
#(
    parameter int PAY_W = 20
) (
    input  logic [PAY_W-1:0] payload,
    input  wcount_t          word_w,
    input  wcount_t          cap_w,
    input  logic             crc_en,
    output word_t            word
);
    localparam int CRC_SPAN = WORD_MAX - CHK_W;

    word_t             pay_ext;
    word_t             masked;
    logic [CHK_W-1:0]  crc;

    assign pay_ext = word_t'(payload);

    // Zero every bit at or above the payload capacity.
    always_comb begin
        for (int i = 0; i < WORD_MAX; i++) begin
            masked[i] = pay_ext[i] & (i < int'(cap_w));
        end
    end

    // Serial CRC over the masked payload, most significant bit first.
    always_comb begin
        logic fb;
        crc = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            fb  = crc[CHK_W-1] ^ masked[i];
            crc = {crc[CHK_W-2:0], 1'b0} ^ (fb ? CHK_POLY : '0);
        end
    end

    // Merge the check field into the top of the selected width.
    always_comb begin
        word = masked;
        if (crc_en) word = masked | (word_t'(crc) << (word_w - wcount_t'(CHK_W)));
    end
endmodule

// File: rtl/link_word_packer.sv
// Top level: packs parallel pixels into mode-dependent link words and
// registers them with a one-cycle valid strobe. Assumes mode pins stay
// steady while a word is formed; pairing is reset when pairing is cleared.
module link_word_packer
    import lwp_pkg::*;
#(
    parameter int PIX_W = 16,
    localparam int PAY_W = PIX_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wide,
    input  logic             mode_hibw,
    input  logic             mode_dbl,
    input  logic             crc_en,
    input  logic             sync_sep,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_hs,
    input  logic             pix_vs,
    output logic             word_valid,
    output logic [31:0]      word_data,
    output logic             word_hs,
    output logic             word_vs,
    output logic [5:0]       pkt_bits
);
    wcount_t           word_w;
    wcount_t           cap_w;
    logic              fire;
    logic [PAY_W-1:0]  payload;
    logic              side_hs;
    logic              side_vs;
    word_t             word_nx;

    lwp_mode_decode u_dec (
        .mode_wide (mode_wide),
        .mode_hibw (mode_hibw),
        .crc_en    (crc_en),
        .word_w    (word_w),
        .cap_w     (cap_w),
        .pkt_bits  (pkt_bits)
    );

    lwp_pair_gather #(.PIX_W(PIX_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_dbl  (mode_dbl),
        .sync_sep  (sync_sep),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_hs    (pix_hs),
        .pix_vs    (pix_vs),
        .fire      (fire),
        .payload   (payload),
        .side_hs   (side_hs),
        .side_vs   (side_vs)
    );

    lwp_word_format #(.PAY_W(PAY_W)) u_fmt (
        .payload (payload),
        .word_w  (word_w),
        .cap_w   (cap_w),
        .crc_en  (crc_en),
        .word    (word_nx)
    );

    // Output register: strobe, word and separated sync flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_hs    <= 1'b0;
            word_vs    <= 1'b0;
        end else begin
            word_valid <= fire;
            word_hs    <= fire & side_hs;
            word_vs    <= fire & side_vs;
            if (fire) word_data <= word_nx;
        end
    end
endmodule

// File: rtl/link_word_packer_chk.sv
// Bound property checker for link_word_packer. Assumes mode pins are
// steady in the cycle a word is formed.
module link_word_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_wide,
    input logic        mode_hibw,
    input logic        mode_dbl,
    input logic        sync_sep,
    input logic        pix_valid,
    input logic        word_valid,
    input logic [31:0] word_data,
    input logic        word_hs,
    input logic        word_vs,
    input logic [5:0]  pkt_bits
);
    // R2: packet size tracks the width select.
    a_r2_pkt_size: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_bits == (mode_wide ? 6'd40 : 6'd30));

    // R3: each single-mode pixel yields a word in the next cycle.
    a_r3_single_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !mode_dbl) |=> word_valid);

    // R3/R6: no word without an accepted pixel.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !word_valid);

    // R5: separated sync only with a valid word and separation enabled.
    a_r5_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (word_hs || word_vs) |-> (word_valid && $past(sync_sep)));

    // R7: narrow words keep bits above 27 clear.
    a_r7_narrow_top: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !$past(mode_wide)) |-> (word_data[31:27] == 5'd0));

    // R7: 24-bit words keep bits above 24 clear.
    a_r7_base_top: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !$past(mode_wide) && !$past(mode_hibw)) |-> (word_data[31:24] == 8'd0));
endmodule

bind link_word_packer link_word_packer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wide  (mode_wide),
    .mode_hibw  (mode_hibw),
    .mode_dbl   (mode_dbl),
    .sync_sep   (sync_sep),
    .pix_valid  (pix_valid),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_hs    (word_hs),
    .word_vs    (word_vs),
    .pkt_bits   (pkt_bits)
);

// File: tb/link_word_packer_test.sv
module link_word_packer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b0, mode_hibw = 1'b0, mode_dbl = 1'b0;
    logic        crc_en = 1'b0, sync_sep = 1'b0;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_data = '0;
    logic        pix_hs = 1'b0, pix_vs = 1'b0;
    logic        word_valid, word_hs, word_vs;
    logic [31:0] word_data;
    logic [5:0]  pkt_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic        hs;
        logic        vs;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [15:0] half_d;
    logic        half_hs, half_vs, half_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_word_packer uut (
        .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .mode_hibw(mode_hibw),
        .mode_dbl(mode_dbl), .crc_en(crc_en), .sync_sep(sync_sep),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_hs(pix_hs), .pix_vs(pix_vs),
        .word_valid(word_valid), .word_data(word_data), .word_hs(word_hs),
        .word_vs(word_vs), .pkt_bits(pkt_bits)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected word from the requirements (R4, R6, R7, R8, R9).
    function automatic logic [31:0] model(logic [15:0] d0, logic h0, logic v0,
                                          logic [15:0] d1, logic h1, logic v1);
        logic [31:0] pay, m;
        logic [5:0]  c;
        logic        fb;
        int w, cap;
        w   = mode_wide ? 32 : (mode_hibw ? 27 : 24);
        cap = crc_en ? w - 6 : w;
        if (!mode_dbl) pay = sync_sep ? {16'b0, d0} : {14'b0, v0, h0, d0};
        else pay = sync_sep ? {16'b0, d1[7:0], d0[7:0]}
                            : {12'b0, v1, h1, d1[7:0], v0, h0, d0[7:0]};
        for (int i = 0; i < 32; i++) m[i] = (i < cap) ? pay[i] : 1'b0;
        if (crc_en) begin
            c = '0;
            for (int i = 25; i >= 0; i--) begin
                fb = c[5] ^ m[i];
                c  = {c[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
            end
            m = m | (32'(c) << (w - 6));
        end
        return m;
    endfunction

    // Driver: present one pixel for one cycle and queue its expected word.
    task automatic send(logic [15:0] d, logic h, logic v, string req);
        exp_t e;
        @(negedge clk);
        pix_valid = 1'b1; pix_data = d; pix_hs = h; pix_vs = v;
        if (!mode_dbl) begin
            e.d = model(d, h, v, '0, 1'b0, 1'b0);
            e.hs = sync_sep & h; e.vs = sync_sep & v; e.req = req;
            sb.push_back(e);
        end else if (!half_pend) begin
            half_d = d; half_hs = h; half_vs = v; half_pend = 1'b1;
        end else begin
            e.d = model(half_d, half_hs, half_vs, d, h, v);
            e.hs = sync_sep & half_hs; e.vs = sync_sep & half_vs; e.req = req;
            sb.push_back(e);
            half_pend = 1'b0;
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic push_literal(logic [31:0] d, logic h, logic v, string req);
        exp_t e;
        e.d = d; e.hs = h; e.vs = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic set_mode(logic w, logic hb, logic db, logic cr, logic sp);
        repeat (2) @(negedge clk);
        mode_wide = w; mode_hibw = hb; mode_dbl = db; crc_en = cr; sync_sep = sp;
        if (!db) half_pend = 1'b0;
        #1;
        check("R2 pkt_bits", 32'(pkt_bits), w ? 32'd40 : 32'd30);
    endtask

    // Monitor: compare every produced word against the queue head.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3/R6 unexpected word actual=%h expected=none", word_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, word_data, e.d);
                check({e.req, " sync"}, {30'b0, word_vs, word_hs}, {30'b0, e.vs, e.hs});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'b0, word_valid}, 32'd0);
        check("R1 data", word_data, 32'd0);
        check("R1 sync", {30'b0, word_vs, word_hs}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'b0, word_valid}, 32'd0);

        // R3/R4: single, 24-bit, inline sync, literal value
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        push_literal(32'h0001A5C3, 1'b0, 1'b0, "R4 inline sync position");
        half_pend = 1'b0;
        @(negedge clk);
        pix_valid = 1'b1; pix_data = 16'hA5C3; pix_hs = 1'b1; pix_vs = 1'b0;
        @(negedge clk);
        pix_valid = 1'b0;
        send(16'hFFFF, 1'b1, 1'b1, "R3 single word");
        send(16'h0000, 1'b0, 1'b1, "R4 vsync bit");

        // R5: separated sync
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        send(16'h1234, 1'b1, 1'b0, "R5 separated hs");
        send(16'hBEEF, 1'b0, 1'b1, "R5 separated vs");

        // R6: pairing, inline and separated, with a gap between halves
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        send(16'h00AB, 1'b1, 1'b0, "R6 pair first");
        repeat (3) @(negedge clk);
        send(16'h00CD, 1'b0, 1'b1, "R6 pair inline");
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        send(16'h7711, 1'b1, 1'b1, "R6 pair first");
        send(16'h8822, 1'b0, 1'b0, "R6 pair separated");

        // R7/R8: pairing with check field overflows capacity in 24-bit words
        set_mode(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        send(16'h00FF, 1'b1, 1'b1, "R7 pair first");
        send(16'h00FF, 1'b1, 1'b1, "R7 truncate with crc");
        set_mode(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        send(16'hC0DE, 1'b1, 1'b0, "R8 crc 27-bit");
        send(16'h0001, 1'b0, 1'b0, "R8 crc 27-bit small");

        // R9: hibw ignored in wide mode
        set_mode(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        send(16'h5A5A, 1'b1, 1'b1, "R9 wide hibw=1");
        set_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        send(16'h5A5A, 1'b1, 1'b1, "R9 wide hibw=0");
        set_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(16'hFFFF, 1'b1, 1'b1, "R7 wide no crc");

        // R10: pending half dropped when pairing is cleared
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        send(16'h0099, 1'b1, 1'b1, "R10 stale half");
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(16'h4321, 1'b0, 1'b0, "R10 single after drop");
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        send(16'h0011, 1'b0, 1'b0, "R10 fresh first");
        send(16'h0022, 1'b1, 1'b0, "R10 fresh pair");

        repeat (4) @(negedge clk);
        check("R6 outstanding words", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule